// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block turns single requests from an internal memory-mapped port (address, write data, byte enables, read/write flag, valid/ready handshake) into timed accesses on an external asynchronous SRAM. The external side is a 32-pin bus made of four 8-bit lanes, plus a chip select, an active-low read strobe, an active-low write strobe and two data-mask pins. Each pin lane has its own output-enable, which stands in for the pad tristate control.

Every accepted access that falls inside the programmed address window runs four timed phases: address setup, address hold, strobe active and strobe recovery. Each phase lasts the number of clock cycles held in its own 4-bit configuration field. Two port widths are supported. With an 8-bit port, one lane carries data and three lanes carry address. With a 16-bit port, two lanes carry data and two carry address. Chip select is decoded from the upper twelve address bits, so the window has 1 MB granularity. A request outside the window finishes at once with an error flag and leaves the bus untouched.

Top module: `asram_bus_ctrl`

## Requirements
- R1: A read in the window drives chip select active for Ts+Th+Tr+Tc consecutive cycles, where each T is the effective phase length. `pad_rd_n` is low for exactly the Tr cycles that start Ts+Th cycles after chip select goes active.
- R2: A write follows the same schedule as a read, with `pad_wr_n` low during the Tr strobe cycles.
- R3: Both strobes are active low. During a read `pad_wr_n` stays 1, during a write `pad_rd_n` stays 1, and outside an access both stay 1.
- R4: A phase field programmed to 0 lasts one cycle. Any other value N lasts N cycles, and the field maximum of 15 lasts 15 cycles.
- R5: With `cfg_wide`=0 (8-bit port), lane 0 (`pad_out[7:0]`) is data. Lanes 1, 2 and 3 carry address bits 7:0, 15:8 and 23:16, and their output-enables are 1 for the whole access.
- R6: With `cfg_wide`=1 (16-bit port), lanes 0 and 1 carry data bits 15:0. Lanes 2 and 3 carry address bits 7:0 and 15:8, and their output-enables are 1 for the whole access.
- R7: The output-enables of the data lanes are 0 in every phase of a read, and 1 in every phase of a write. While idle, all four output-enables are 0.
- R8: A read samples the data lanes on the last strobe cycle. After the recovery phase it returns that value on `rsp_rdata` with a one-cycle `rsp_valid` and `rsp_err`=0. On an 8-bit port bits 15:8 are 0. A write returns `rsp_rdata`=0.
- R9: Chip select is active when start ≤ `req_addr[31:20]` ≤ end, both bounds inclusive. The active level equals `cfg_cs_act_high`.
- R10: A request outside the window raises `rsp_valid` with `rsp_err`=1 in the cycle after acceptance. It leaves chip select inactive, both strobes at 1 and all output-enables at 0.
- R11: After every access, chip select stays inactive for at least 2 cycles before the next access. `req_ready` is 1 only while the block is idle.
- R12: During a write, `pad_dm[j]` takes the level `cfg_dm_act_high` for each data lane j whose `req_be[j]` is 0. In every other case it takes the opposite level. On an 8-bit port only `pad_dm[0]` can be asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for data lanes 0 and 1 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Request missed the window |
| cfg_wide | input | 1 | 0 = 8-bit port, 1 = 16-bit port |
| cfg_win_start | input | 12 | First 1 MB block of the window |
| cfg_win_end | input | 12 | Last 1 MB block of the window |
| cfg_cs_act_high | input | 1 | Active level of chip select |
| cfg_dm_act_high | input | 1 | Active level of the data-mask pins |
| cfg_t_setup | input | 4 | Address setup length in cycles |
| cfg_t_hold | input | 4 | Address hold length in cycles |
| cfg_t_strobe | input | 4 | Strobe active length in cycles |
| cfg_t_recov | input | 4 | Strobe recovery length in cycles |
| pad_out | output | 32 | Lane output values |
| pad_oe | output | 4 | Per-lane output-enable |
| pad_in | input | 16 | Input values of the two data-capable lanes |
| pad_cs | output | 1 | Chip select |
| pad_rd_n | output | 1 | Read strobe, active low |
| pad_wr_n | output | 1 | Write strobe, active low |
| pad_dm | output | 2 | Data mask for data lanes 0 and 1 |

## Verification
The assertions assume that the configuration inputs stay steady while an access is in flight, that requests arrive only through the valid/ready handshake, and that `cfg_win_start` is not greater than `cfg_win_end`. The bench changes timing, width and polarity settings only between accesses, after `req_ready` has returned. It presents one request at a time and drops `req_valid` right after acceptance. Its SRAM model changes `pad_in` on every strobe cycle, so only a sample taken in the last strobe cycle gives the expected read data.

// File: rtl/asram_pkg.sv
// Shared constants and state encoding for the asynchronous SRAM controller.
// Assumes a fixed pad arrangement of four 8-bit lanes, two of them data-capable.
package asram_pkg;
    localparam int LANE_W     = 8;
    localparam int LANES      = 4;
    localparam int DATA_LANES = 2;
    localparam int WIN_LSB    = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_STROBE,
        ST_RECOV,
        ST_GAP
    } seq_state_t;
endpackage

// File: rtl/asram_win_decode.sv
// Window decoder: flags an address whose upper bits fall in an inclusive block range.
// Assumes start <= end; the block size is 2**LSB bytes.
module asram_win_decode #(
    parameter int ADDR_W = 32,
    parameter int LSB    = 20,
    localparam int TAG_W = ADDR_W - LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  win_start,
    input  logic [TAG_W-1:0]  win_end,
    output logic              hit
);
    logic [TAG_W-1:0] tag;

    // Compare the block number against both inclusive bounds.
    always_comb begin
        tag = addr[ADDR_W-1:LSB];
        hit = (tag >= win_start) && (tag <= win_end);
    end
endmodule

// File: rtl/asram_phase_seq.sv
// Phase sequencer: steps through setup, hold, strobe and recovery, each lasting its
// programmed cycle count (0 counts as 1), then enforces an idle gap before the next start.
// Assumes the duration inputs are stable from start until the sequence ends.
module asram_phase_seq
    import asram_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int GAP_CYC = 2,
    localparam int GW     = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] t_setup,
    input  logic [CNT_W-1:0] t_hold,
    input  logic [CNT_W-1:0] t_strobe,
    input  logic [CNT_W-1:0] t_recov,
    output logic             idle,
    output logic             bus_active,
    output logic             strobe_on,
    output logic             strobe_last,
    output logic             done
);
    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [GW-1:0]    gcnt;

    function automatic logic [CNT_W-1:0] first_cnt(input logic [CNT_W-1:0] d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

    // Advance the phase when its down-counter reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            gcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_SETUP;
                    cnt   <= first_cnt(t_setup);
                end
                ST_SETUP: if (cnt == '0) begin
                    state <= ST_HOLD;
                    cnt   <= first_cnt(t_hold);
                end else cnt <= cnt - 1'b1;
                ST_HOLD: if (cnt == '0) begin
                    state <= ST_STROBE;
                    cnt   <= first_cnt(t_strobe);
                end else cnt <= cnt - 1'b1;
                ST_STROBE: if (cnt == '0) begin
                    state <= ST_RECOV;
                    cnt   <= first_cnt(t_recov);
                end else cnt <= cnt - 1'b1;
                ST_RECOV: if (cnt == '0) begin
                    state <= ST_GAP;
                    gcnt  <= GW'(GAP_CYC - 1);
                end else cnt <= cnt - 1'b1;
                ST_GAP: if (gcnt == '0) state <= ST_IDLE;
                        else gcnt <= gcnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode phase flags from the registered state.
    always_comb begin
        idle        = (state == ST_IDLE);
        bus_active  = (state == ST_SETUP) || (state == ST_HOLD) ||
                      (state == ST_STROBE) || (state == ST_RECOV);
        strobe_on   = (state == ST_STROBE);
        strobe_last = strobe_on && (cnt == '0);
        done        = (state == ST_RECOV) && (cnt == '0);
    end

    // The strobe phase is only ever entered from the hold phase.
    assert_strobe_after_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_on) |-> $past(state) == ST_HOLD);

    // Once an access ends, the bus stays inactive for at least another cycle.
    assert_idle_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_active) |=> !bus_active);
endmodule

// File: rtl/asram_lane_mux.sv
// Lane multiplexer: places address bytes and data bytes on the four pad lanes by port
// width, sets per-lane output-enables and data-mask pins, and gathers read data.
// Assumes only lanes 0 and 1 can ever carry data.
module asram_lane_mux
    import asram_pkg::*;
#(
    localparam int BUS_W  = LANES * LANE_W,
    localparam int DATA_W = DATA_LANES * LANE_W
) (
    input  logic                  wide,
    input  logic                  active,
    input  logic                  is_write,
    input  logic [23:0]           addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_LANES-1:0] be,
    input  logic                  dm_act_high,
    input  logic [DATA_W-1:0]     pad_in,
    output logic [BUS_W-1:0]      pad_out,
    output logic [LANES-1:0]      pad_oe,
    output logic [DATA_LANES-1:0] pad_dm,
    output logic [DATA_W-1:0]     rd_word
);
    logic [BUS_W-1:0] img;
    logic [LANES-1:0] is_data;

    // Build the lane image and data-lane map for the selected width.
    always_comb begin
        if (wide) begin
            img     = {addr[15:8], addr[7:0], wdata[15:0]};
            is_data = 4'b0011;
            rd_word = pad_in;
        end else begin
            img     = {addr[23:16], addr[15:8], addr[7:0], wdata[7:0]};
            is_data = 4'b0001;
            rd_word = {8'h00, pad_in[7:0]};
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Drive each lane only during an access; data lanes face outward only on writes.
        always_comb begin
            pad_out[g*LANE_W +: LANE_W] = active ? img[g*LANE_W +: LANE_W] : '0;
            pad_oe[g] = active && (!is_data[g] || is_write);
        end
    end

    for (genvar j = 0; j < DATA_LANES; j++) begin : g_mask
        // Assert the mask on a disabled byte of a write, at the configured level.
        always_comb begin
            pad_dm[j] = (active && is_write && is_data[j] && !be[j]) ? dm_act_high : !dm_act_high;
        end
    end
endmodule

// File: rtl/asram_bus_ctrl.sv
// Asynchronous SRAM bus controller top: accepts one request at a time, checks the chip
// select window, runs the four-phase pin sequence and returns a one-cycle response.
// Assumes configuration inputs are held steady while an access is in progress.
module asram_bus_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 4,
    parameter int GAP_CYC = 2,
    localparam int TAG_W  = ADDR_W - WIN_LSB,
    localparam int BUS_W  = LANES * LANE_W,
    localparam int DATA_W = DATA_LANES * LANE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_LANES-1:0] req_be,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  rsp_err,
    input  logic                  cfg_wide,
    input  logic [TAG_W-1:0]      cfg_win_start,
    input  logic [TAG_W-1:0]      cfg_win_end,
    input  logic                  cfg_cs_act_high,
    input  logic                  cfg_dm_act_high,
    input  logic [CNT_W-1:0]      cfg_t_setup,
    input  logic [CNT_W-1:0]      cfg_t_hold,
    input  logic [CNT_W-1:0]      cfg_t_strobe,
    input  logic [CNT_W-1:0]      cfg_t_recov,
    output logic [BUS_W-1:0]      pad_out,
    output logic [LANES-1:0]      pad_oe,
    input  logic [DATA_W-1:0]     pad_in,
    output logic                  pad_cs,
    output logic                  pad_rd_n,
    output logic                  pad_wr_n,
    output logic [DATA_LANES-1:0] pad_dm
);
    logic                  hit, accept, idle, bus_active, strobe_on, strobe_last, done;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     wdata_q, rdata_q, rd_word;
    logic [DATA_LANES-1:0] be_q;
    logic                  wr_q, rsp_valid_q, rsp_err_q;

    asram_win_decode #(.ADDR_W(ADDR_W), .LSB(WIN_LSB)) u_win (
        .addr(req_addr), .win_start(cfg_win_start), .win_end(cfg_win_end), .hit(hit)
    );

    asram_phase_seq #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept && hit),
        .t_setup(cfg_t_setup), .t_hold(cfg_t_hold),
        .t_strobe(cfg_t_strobe), .t_recov(cfg_t_recov),
        .idle(idle), .bus_active(bus_active), .strobe_on(strobe_on),
        .strobe_last(strobe_last), .done(done)
    );

    asram_lane_mux u_lanes (
        .wide(cfg_wide), .active(bus_active), .is_write(wr_q), .addr(addr_q[23:0]),
        .wdata(wdata_q), .be(be_q), .dm_act_high(cfg_dm_act_high), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_dm(pad_dm), .rd_word(rd_word)
    );

    // Handshake: requests are taken only while the sequencer is idle.
    always_comb begin
        req_ready = idle;
        accept    = req_valid && idle;
    end

    // Latch the request, capture read data and produce the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            be_q        <= '0;
            wr_q        <= 1'b0;
            rdata_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                be_q      <= req_be;
                wr_q      <= req_write;
                rdata_q   <= '0;
                rsp_err_q <= !hit;
                if (!hit) rsp_valid_q <= 1'b1;
            end
            if (strobe_last && !wr_q) rdata_q <= rd_word;
            if (done) begin
                rsp_valid_q <= 1'b1;
                rsp_err_q   <= 1'b0;
            end
        end
    end

    // Control pins follow the registered phase.
    always_comb begin
        pad_cs    = bus_active ? cfg_cs_act_high : !cfg_cs_act_high;
        pad_rd_n  = !(strobe_on && !wr_q);
        pad_wr_n  = !(strobe_on && wr_q);
        rsp_valid = rsp_valid_q;
        rsp_err   = rsp_err_q;
        rsp_rdata = rdata_q;
    end

    // Read and write strobes are never low together.
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pad_rd_n || pad_wr_n);

    // Data lane 0 never drives while the read strobe is low.
    assert_read_lane_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_rd_n |-> !pad_oe[0]);

    // The top lane always carries address while chip select is active.
    assert_addr_lane_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_cs == cfg_cs_act_high) |-> pad_oe[LANES-1]);

    // A window miss completes with the bus quiet.
    assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ((pad_cs != cfg_cs_act_high) && pad_rd_n && pad_wr_n && (pad_oe == '0)));

    // The request port is only ready while chip select is inactive.
    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (pad_cs != cfg_cs_act_high));
endmodule

// File: tb/sim_asram_bus_ctrl.sv
module sim_asram_bus_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        err;
        logic [15:0] data;
    } rsp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        cfg_wide = 1'b0, cfg_cs_act_high = 1'b0, cfg_dm_act_high = 1'b1;
    logic [11:0] cfg_win_start = 12'h100, cfg_win_end = 12'h102;
    logic [3:0]  cfg_t_setup = 4'd2, cfg_t_hold = 4'd1, cfg_t_strobe = 4'd3, cfg_t_recov = 4'd1;
    logic [15:0] pad_in = '0;
    logic        req_ready, rsp_valid, rsp_err, pad_cs, pad_rd_n, pad_wr_n;
    logic [15:0] rsp_rdata;
    logic [31:0] pad_out;
    logic [3:0]  pad_oe;
    logic [1:0]  pad_dm;

    int checks = 0;
    int fails = 0;
    rsp_item_t exp_q[$];
    logic [7:0] seed_lo = 8'h10, seed_hi = 8'h80, rd_k = 8'h00;

    asram_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_wide(cfg_wide), .cfg_win_start(cfg_win_start), .cfg_win_end(cfg_win_end),
        .cfg_cs_act_high(cfg_cs_act_high), .cfg_dm_act_high(cfg_dm_act_high),
        .cfg_t_setup(cfg_t_setup), .cfg_t_hold(cfg_t_hold),
        .cfg_t_strobe(cfg_t_strobe), .cfg_t_recov(cfg_t_recov),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .pad_cs(pad_cs),
        .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n), .pad_dm(pad_dm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic int eff(input logic [3:0] t);
        return (t == 4'd0) ? 1 : int'(t);
    endfunction

    // SRAM model: read data changes on every strobe cycle.
    always @(negedge clk) begin
        if (!pad_rd_n) rd_k = rd_k + 8'd1;
        else rd_k = 8'd0;
        pad_in = {seed_hi + rd_k, seed_lo + rd_k};
    end

    // Monitor: compare each response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 unexpected response: actual=%h expected=none", {rsp_err, rsp_rdata});
            end else begin
                rsp_item_t e;
                e = exp_q.pop_front();
                check(e.err ? "R10" : "R8", "response", {15'd0, rsp_err, rsp_rdata}, {15'd0, e.err, e.data});
            end
        end
    end

    // Driver: issue one request, push its expected response, check the pins cycle by cycle.
    task automatic access(input logic wr, input logic [31:0] a, input logic [15:0] wd, input logic [1:0] be);
        logic miss, wide, csa;
        int ts, th, tr, tc, tot;
        logic [31:0] img, mask;
        logic [3:0] oe_exp;
        logic [15:0] rexp;
        rsp_item_t item;
        while (!req_ready) @(negedge clk);
        miss = (a[31:20] < cfg_win_start) || (a[31:20] > cfg_win_end);
        wide = cfg_wide; csa = cfg_cs_act_high;
        ts = eff(cfg_t_setup); th = eff(cfg_t_hold); tr = eff(cfg_t_strobe); tc = eff(cfg_t_recov);
        tot = ts + th + tr + tc;
        if (wide) begin
            img = {a[15:8], a[7:0], wd};
            oe_exp = {2'b11, wr, wr};
            rexp = {seed_hi + 8'(tr), seed_lo + 8'(tr)};
        end else begin
            img = {a[23:16], a[15:8], a[7:0], wd[7:0]};
            oe_exp = {3'b111, wr};
            rexp = {8'h00, seed_lo + 8'(tr)};
        end
        mask = wr ? 32'hFFFF_FFFF : (wide ? 32'hFFFF_0000 : 32'hFFFF_FF00);
        item.err = miss;
        item.data = (miss || wr) ? 16'h0000 : rexp;
        exp_q.push_back(item);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        if (miss) begin
            check("R10", "miss pins", {28'd0, pad_cs, pad_rd_n, pad_wr_n, |pad_oe}, {28'd0, !csa, 1'b1, 1'b1, 1'b0});
            return;
        end
        for (int i = 0; i < tot; i++) begin
            logic stb;
            logic [1:0] dm_exp;
            stb = (i >= ts + th) && (i < ts + th + tr);
            check(wr ? "R2" : "R1", "cs/rd_n/wr_n (R3 R4 R9)", {29'd0, pad_cs, pad_rd_n, pad_wr_n},
                  {29'd0, csa, !(stb && !wr), !(stb && wr)});
            check("R7", "lane output-enables", {28'd0, pad_oe}, {28'd0, oe_exp});
            check(wide ? "R6" : "R5", "lane values", pad_out & mask, img & mask);
            dm_exp[0] = (wr && !be[0]) ? cfg_dm_act_high : !cfg_dm_act_high;
            dm_exp[1] = (wr && wide && !be[1]) ? cfg_dm_act_high : !cfg_dm_act_high;
            check("R12", "data mask", {30'd0, pad_dm}, {30'd0, dm_exp});
            @(negedge clk);
        end
        for (int g = 0; g < 2; g++) begin
            check("R11", "idle gap", {28'd0, pad_cs, req_ready, pad_rd_n, pad_wr_n}, {28'd0, !csa, 1'b0, 1'b1, 1'b1});
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3", "reset pins", {27'd0, pad_cs, pad_rd_n, pad_wr_n, req_ready, rsp_valid}, {27'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
        check("R7", "reset output-enables", {28'd0, pad_oe}, 32'd0);

        // R5 R1 R2 R12: 8-bit port, cs active low, mask active high.
        access(1'b1, 32'h1001_2345, 16'h00A5, 2'b11);
        seed_lo = 8'h20;
        access(1'b0, 32'h1001_2345, 16'h0000, 2'b11);
        access(1'b1, 32'h1000_0001, 16'h005A, 2'b00);
        // R9 boundaries: last byte of the end block hits, the next block and below start miss.
        access(1'b1, 32'h102F_FFFF, 16'h00C3, 2'b01);
        access(1'b0, 32'h1030_0000, 16'h0000, 2'b11);
        access(1'b0, 32'h0FFF_FFFF, 16'h0000, 2'b11);

        // R6 R4: 16-bit port, zero fields, maximum strobe, cs active high, mask active low.
        cfg_wide = 1'b1; cfg_cs_act_high = 1'b1; cfg_dm_act_high = 1'b0;
        cfg_t_setup = 4'd0; cfg_t_hold = 4'd0; cfg_t_strobe = 4'd15; cfg_t_recov = 4'd2;
        access(1'b1, 32'h1015_ABCD, 16'hBEEF, 2'b01);
        seed_lo = 8'h31; seed_hi = 8'hC2;
        access(1'b0, 32'h1015_ABCD, 16'h0000, 2'b11);
        access(1'b1, 32'h1020_1234, 16'h1357, 2'b10);

        // R4 R8: long setup, single-cycle strobe, back-to-back reads.
        cfg_t_setup = 4'd3; cfg_t_hold = 4'd2; cfg_t_strobe = 4'd1; cfg_t_recov = 4'd0;
        seed_lo = 8'h05; seed_hi = 8'h44;
        access(1'b0, 32'h1000_0F0E, 16'h0000, 2'b11);
        access(1'b0, 32'h1020_0000, 16'h0000, 2'b11);
        cfg_wide = 1'b0;
        access(1'b0, 32'h1020_0000, 16'h0000, 2'b11);
        access(1'b1, 32'hFFF0_0000, 16'h0000, 2'b11);

        repeat (3) @(negedge clk);
        check("R8", "outstanding responses", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule